// File: doc/BRIEF.md
# Video Test Pattern Generator with Go/No-Go Self-Test

This block produces a stream of parallel digital video samples for bring-up and production test. Each sample is a 20-bit word: a 10-bit luma value and a 10-bit chroma value, with Cb and Cr taking turns. A pixel-rate clock enable marks each new sample. The block walks a full field raster, active area and blanking included, in either a standard-definition or a high-definition format. The line lengths, line counts, active sizes and the standard-definition clock divide ratio are all parameters.

Software writes a 6-bit pattern code and sets an enable to start the block. The code picks the format and one of four pictures: flat black, an equalizer-stress half field, a PLL-stress half field, or eight 75% colour bars. The colour bars can have their transitions softened. Clearing the enable stops the block and returns it to idle.

The block also runs a self-test. The generated words leave the chip, come back on a loopback input, and are compared line by line through a running checksum over the active samples. A mismatch latches an internal failure. The pass output rises only after two complete fields have passed with no mismatch. After reset the block is in standard definition. A code with the high-definition bit set is all it takes to change format.

Top module: `vtpg_top`

## Requirements
- R1: After reset, with `tpg_en` low, `pix_ce`, `vid_data`, `vid_active`, `vid_fend`, `pass` and `hd_mode` are all 0.
- R2: `pat_code` and `filt_en` are captured on the clock edge where `tpg_en` is first seen high. Later changes to them during the run have no effect. Bit 5 selects HD (1) or SD (0). Bits [1:0] select the picture: 00 black, 01 PLL-stress, 10 equalizer-stress, 11 colour bars. Bits [4:2] are ignored.
- R3: `hd_mode` shows the captured format bit. In SD, `pix_ce` pulses once every `SD_DIV` clocks. In HD it is high on every clock.
- R4: Samples appear in raster order starting at h=0, v=0. Each line holds H_TOTAL samples and each field holds V_TOTAL lines.
  - `vid_active` is 1 exactly when h < H_ACT and v < V_ACT.
  - `vid_fend` is 1 only on the last sample of a field.
  - Every blanking sample is Y=0x040, C=0x200.
- R5: `vid_data[19:10]` carries Y and `vid_data[9:0]` carries C. C is Cb when h is even and Cr when h is odd.
- R6: With the black picture, every active sample is Y=0x040, Cb=Cr=0x200.
- R7: The equalizer-stress picture fills active lines with v < V_ACT/2 with Y=0x198, Cb=Cr=0x300, and leaves the rest black. The PLL-stress picture fills active lines with v >= V_ACT/2 with Y=0x110, Cb=Cr=0x200, and leaves the rest black.
- R8: The colour bar picture has eight bars, each H_ACT/8 samples wide, with bar index h/(H_ACT/8). The bar colours (Y,Cb,Cr), in index order, are:
  - 0 (2D0,200,200)
  - 1 (288,0B0,238)
  - 2 (20C,270,0B0)
  - 3 (1C0,120,0E8)
  - 4 (150,2E0,318)
  - 5 (104,190,350)
  - 6 (08C,350,1C8)
  - 7 (040,200,200)
- R9: With the filter captured on, the first sample of bars 1 to 7 carries floor((previous bar + this bar)/2). This applies separately to Y and to the C component sent on that sample.
- R10: When no mismatch has occurred, `pass` rises one clock after the output sample that carries the second `vid_fend` of the run. It is 0 before that.
- R11: A difference between `lb_data` and `vid_data` on any active sample causes a per-line checksum mismatch (sum modulo 2^CSUM_W). After a mismatch, `pass` stays 0 for the rest of the run. Differences on blanking samples are ignored.
- R12: Within two clocks of the edge that sees `tpg_en` low, `pix_ce`, `vid_data` and `pass` are 0. A new run starts again at h=0, v=0 with the failure latch cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tpg_en | input | 1 | Runs generation and self-test while high |
| pat_code | input | 6 | Format and picture select, captured at start |
| filt_en | input | 1 | Bar transition filter request, captured at start |
| lb_data | input | 20 | Loopback copy of `vid_data`, same cycle |
| vid_data | output | 20 | Sample word {Y, C} |
| pix_ce | output | 1 | One-clock pulse marking a new sample |
| vid_active | output | 1 | Current sample lies in the active picture |
| vid_fend | output | 1 | Current sample is the last of a field |
| hd_mode | output | 1 | Captured format, 1 = HD |
| pass | output | 1 | Self-test passed |

## Verification
If the raster counters or bar counters are wrong, the fault shows on the very next `pix_ce` sample. It appears either as a wrong word or as `vid_active`/`vid_fend` at the wrong position, and the bench compares every sample of two or three fields against its own model. A broken rate divider shows up as incorrect spacing between `pix_ce` pulses within a few clocks. A broken failure latch or field counter shows up only at the second field boundary, when `pass` rises when it should not or stays low when it should rise. That is why the bench checks `pass` on the sample before that boundary and on the clock after it.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;

   localparam int COMP_W = 10;
   localparam int WORD_W = 2 * COMP_W;

   typedef enum logic [1:0] {
      PAT_BLACK = 2'd0,
      PAT_PLL   = 2'd1,
      PAT_EQ    = 2'd2,
      PAT_BARS  = 2'd3
   } pat_e;

   typedef struct packed {
      logic hd;
      pat_e pat;
      logic filt;
   } cfg_t;

   typedef struct packed {
      logic [COMP_W-1:0] y;
      logic [COMP_W-1:0] cb;
      logic [COMP_W-1:0] cr;
   } ycc_t;

   localparam logic [COMP_W-1:0] LVL_BLK_Y = 10'h040;
   localparam logic [COMP_W-1:0] LVL_MID_C = 10'h200;
   localparam logic [COMP_W-1:0] LVL_EQ_Y  = 10'h198;
   localparam logic [COMP_W-1:0] LVL_EQ_C  = 10'h300;
   localparam logic [COMP_W-1:0] LVL_PLL_Y = 10'h110;
   localparam logic [COMP_W-1:0] LVL_PLL_C = 10'h200;

   // 75% amplitude bars, left to right
   function automatic ycc_t bar_colour(input logic [2:0] idx);
      ycc_t c;
      unique case (idx)
         3'd0: c = '{y: 10'h2D0, cb: 10'h200, cr: 10'h200};
         3'd1: c = '{y: 10'h288, cb: 10'h0B0, cr: 10'h238};
         3'd2: c = '{y: 10'h20C, cb: 10'h270, cr: 10'h0B0};
         3'd3: c = '{y: 10'h1C0, cb: 10'h120, cr: 10'h0E8};
         3'd4: c = '{y: 10'h150, cb: 10'h2E0, cr: 10'h318};
         3'd5: c = '{y: 10'h104, cb: 10'h190, cr: 10'h350};
         3'd6: c = '{y: 10'h08C, cb: 10'h350, cr: 10'h1C8};
         default: c = '{y: 10'h040, cb: 10'h200, cr: 10'h200};
      endcase
      return c;
   endfunction

   function automatic logic [COMP_W-1:0] mid(input logic [COMP_W-1:0] a,
                                             input logic [COMP_W-1:0] b);
      logic [COMP_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[COMP_W:1];
   endfunction

endpackage

// File: rtl/vtpg_rate.sv
module vtpg_rate #(
   parameter int SD_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hd,
   output logic ce
);

   if (SD_DIV < 1) begin : g_bad_div
      $error("vtpg_rate: SD_DIV must be at least 1");
   end

   if (SD_DIV == 1) begin : g_full_rate
      assign ce = run;
   end else begin : g_divided
      localparam int DIV_W = $clog2(SD_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SD_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (!run || div_q == DIV_LAST) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end

      assign ce = run && (hd || div_q == DIV_LAST);

      assert_sd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !hd && ce) |=> !ce);
   end

endmodule

// File: rtl/vtpg_raster.sv
module vtpg_raster #(
   parameter int SD_H_TOTAL = 858,
   parameter int SD_H_ACT   = 720,
   parameter int SD_V_TOTAL = 262,
   parameter int SD_V_ACT   = 240,
   parameter int HD_H_TOTAL = 2200,
   parameter int HD_H_ACT   = 1920,
   parameter int HD_V_TOTAL = 562,
   parameter int HD_V_ACT   = 540,
   parameter int N_BARS     = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       ce,
   input  logic       hd,
   output logic       h_odd,
   output logic       active,
   output logic       upper,
   output logic       line_last,
   output logic       field_last,
   output logic [2:0] bar_idx,
   output logic       bar_first
);

   localparam int H_MAX  = (SD_H_TOTAL > HD_H_TOTAL) ? SD_H_TOTAL : HD_H_TOTAL;
   localparam int V_MAX  = (SD_V_TOTAL > HD_V_TOTAL) ? SD_V_TOTAL : HD_V_TOTAL;
   localparam int H_W    = $clog2(H_MAX + 1);
   localparam int V_W    = $clog2(V_MAX + 1);
   localparam int SD_BW  = SD_H_ACT / N_BARS;
   localparam int HD_BW  = HD_H_ACT / N_BARS;
   localparam int BW_MAX = (SD_BW > HD_BW) ? SD_BW : HD_BW;
   localparam int B_W    = $clog2(BW_MAX + 1);

   if (N_BARS != 8) begin : g_bad_bars
      $error("vtpg_raster: the bar table holds exactly eight colours");
   end
   if (SD_H_ACT % N_BARS != 0 || HD_H_ACT % N_BARS != 0) begin : g_bad_width
      $error("vtpg_raster: active width must divide into equal bars");
   end
   if (SD_H_ACT >= SD_H_TOTAL || HD_H_ACT >= HD_H_TOTAL) begin : g_bad_hblank
      $error("vtpg_raster: each line needs horizontal blanking");
   end
   if (SD_V_ACT > SD_V_TOTAL || HD_V_ACT > HD_V_TOTAL || SD_V_ACT < 2 || HD_V_ACT < 2) begin : g_bad_v
      $error("vtpg_raster: active line count out of range");
   end

   logic [H_W-1:0] h_q, h_last, h_act;
   logic [V_W-1:0] v_q, v_last, v_act, v_half;
   logic [B_W-1:0] bpos_q, bw_last;
   logic [2:0]     bidx_q;
   logic           h_in_act;

   assign h_last  = hd ? H_W'(HD_H_TOTAL - 1) : H_W'(SD_H_TOTAL - 1);
   assign h_act   = hd ? H_W'(HD_H_ACT)       : H_W'(SD_H_ACT);
   assign v_last  = hd ? V_W'(HD_V_TOTAL - 1) : V_W'(SD_V_TOTAL - 1);
   assign v_act   = hd ? V_W'(HD_V_ACT)       : V_W'(SD_V_ACT);
   assign v_half  = hd ? V_W'(HD_V_ACT / 2)   : V_W'(SD_V_ACT / 2);
   assign bw_last = hd ? B_W'(HD_BW - 1)      : B_W'(SD_BW - 1);

   assign h_in_act = h_q < h_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q    <= '0;
         v_q    <= '0;
         bpos_q <= '0;
         bidx_q <= '0;
      end else if (!run) begin
         h_q    <= '0;
         v_q    <= '0;
         bpos_q <= '0;
         bidx_q <= '0;
      end else if (ce) begin
         if (h_q == h_last) begin
            h_q    <= '0;
            v_q    <= (v_q == v_last) ? '0 : v_q + 1'b1;
            bpos_q <= '0;
            bidx_q <= '0;
         end else begin
            h_q <= h_q + 1'b1;
            if (h_in_act) begin
               if (bpos_q == bw_last) begin
                  bpos_q <= '0;
                  bidx_q <= bidx_q + 1'b1;
               end else begin
                  bpos_q <= bpos_q + 1'b1;
               end
            end
         end
      end
   end

   assign h_odd      = h_q[0];
   assign active     = h_in_act && (v_q < v_act);
   assign upper      = v_q < v_half;
   assign line_last  = h_q == h_last;
   assign field_last = line_last && (v_q == v_last);
   assign bar_idx    = bidx_q;
   assign bar_first  = (bpos_q == '0) && (bidx_q != 3'd0);

   assert_h_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (h_q <= h_last && v_q <= v_last));

   assert_bar_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && active) |-> bpos_q <= bw_last);

endmodule

// File: rtl/vtpg_pattern.sv
module vtpg_pattern import vtpg_pkg::*; #(
   parameter bit FILTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ce,
   input  cfg_t              cfg,
   input  logic              h_odd,
   input  logic              active,
   input  logic              upper,
   input  logic              line_last,
   input  logic              field_last,
   input  logic [2:0]        bar_idx,
   input  logic              bar_first,
   output logic [WORD_W-1:0] vid_data,
   output logic              pix_ce,
   output logic              vid_active,
   output logic              vid_lend,
   output logic              vid_fend
);

   ycc_t bar_cur, bar_col, px;
   logic [WORD_W-1:0] word;

   assign bar_cur = bar_colour(bar_idx);

   if (FILTER_EN) begin : g_filter
      ycc_t bar_prev, bar_soft;
      assign bar_prev = bar_colour(bar_idx - 3'd1);
      assign bar_soft = '{y:  mid(bar_prev.y,  bar_cur.y),
                          cb: mid(bar_prev.cb, bar_cur.cb),
                          cr: mid(bar_prev.cr, bar_cur.cr)};
      assign bar_col  = (cfg.filt && bar_first) ? bar_soft : bar_cur;
   end else begin : g_plain
      logic unused_filter;
      assign unused_filter = cfg.filt ^ bar_first;
      assign bar_col       = bar_cur;
   end

   always_comb begin
      px = '{y: LVL_BLK_Y, cb: LVL_MID_C, cr: LVL_MID_C};
      if (active) begin
         unique case (cfg.pat)
            PAT_BLACK: ;
            PAT_PLL:   if (!upper) px = '{y: LVL_PLL_Y, cb: LVL_PLL_C, cr: LVL_PLL_C};
            PAT_EQ:    if (upper)  px = '{y: LVL_EQ_Y,  cb: LVL_EQ_C,  cr: LVL_EQ_C};
            PAT_BARS:  px = bar_col;
            default:   ;
         endcase
      end
      word = {px.y, h_odd ? px.cr : px.cb};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_data   <= '0;
         pix_ce     <= 1'b0;
         vid_active <= 1'b0;
         vid_lend   <= 1'b0;
         vid_fend   <= 1'b0;
      end else if (!run) begin
         vid_data   <= '0;
         pix_ce     <= 1'b0;
         vid_active <= 1'b0;
         vid_lend   <= 1'b0;
         vid_fend   <= 1'b0;
      end else begin
         pix_ce   <= ce;
         vid_lend <= ce && line_last;
         vid_fend <= ce && field_last;
         if (ce) begin
            vid_data   <= word;
            vid_active <= active;
         end
      end
   end

   assert_blank_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ce && !vid_active) |-> vid_data == {LVL_BLK_Y, LVL_MID_C});

   assert_fend_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vid_fend |-> (pix_ce && vid_lend && !vid_active));

endmodule

// File: rtl/vtpg_check.sv
module vtpg_check import vtpg_pkg::*; #(
   parameter int CSUM_W      = 24,
   parameter int PASS_FIELDS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              pix_ce,
   input  logic              vid_active,
   input  logic              vid_lend,
   input  logic              vid_fend,
   input  logic [WORD_W-1:0] vid_data,
   input  logic [WORD_W-1:0] lb_data,
   output logic              pass
);

   localparam int F_W = $clog2(PASS_FIELDS + 1);
   localparam logic [F_W-1:0] F_GOAL = F_W'(PASS_FIELDS);

   if (CSUM_W < WORD_W) begin : g_bad_csum
      $error("vtpg_check: checksum narrower than a sample word");
   end
   if (PASS_FIELDS < 1) begin : g_bad_fields
      $error("vtpg_check: at least one field must elapse before pass");
   end

   logic [CSUM_W-1:0] acc_ref_q, acc_lb_q, sum_ref, sum_lb;
   logic [F_W-1:0]    fcnt_q, fcnt_n;
   logic              fail_q, fail_n, mism;

   assign sum_ref = acc_ref_q + (vid_active ? CSUM_W'(vid_data) : '0);
   assign sum_lb  = acc_lb_q  + (vid_active ? CSUM_W'(lb_data)  : '0);
   assign mism    = pix_ce && vid_lend && (sum_ref != sum_lb);
   assign fail_n  = fail_q || mism;
   assign fcnt_n  = (pix_ce && vid_fend && fcnt_q != F_GOAL) ? fcnt_q + 1'b1 : fcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_ref_q <= '0;
         acc_lb_q  <= '0;
         fcnt_q    <= '0;
         fail_q    <= 1'b0;
         pass      <= 1'b0;
      end else if (!run) begin
         acc_ref_q <= '0;
         acc_lb_q  <= '0;
         fcnt_q    <= '0;
         fail_q    <= 1'b0;
         pass      <= 1'b0;
      end else begin
         if (pix_ce) begin
            acc_ref_q <= vid_lend ? '0 : sum_ref;
            acc_lb_q  <= vid_lend ? '0 : sum_lb;
         end
         fcnt_q <= fcnt_n;
         fail_q <= fail_n;
         pass   <= !fail_n && (fcnt_n == F_GOAL);
      end
   end

   assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run && fail_q) |=> (fail_q || !run));

   assert_pass_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> !fail_q);

   assert_pass_at_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> $past(pix_ce && vid_fend));

endmodule

// File: rtl/vtpg_top.sv
module vtpg_top import vtpg_pkg::*; #(
   parameter int SD_H_TOTAL  = 858,
   parameter int SD_H_ACT    = 720,
   parameter int SD_V_TOTAL  = 262,
   parameter int SD_V_ACT    = 240,
   parameter int HD_H_TOTAL  = 2200,
   parameter int HD_H_ACT    = 1920,
   parameter int HD_V_TOTAL  = 562,
   parameter int HD_V_ACT    = 540,
   parameter int SD_DIV      = 2,
   parameter bit FILTER_EN   = 1'b1,
   parameter int CSUM_W      = 24,
   parameter int PASS_FIELDS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tpg_en,
   input  logic [5:0]  pat_code,
   input  logic        filt_en,
   input  logic [19:0] lb_data,
   output logic [19:0] vid_data,
   output logic        pix_ce,
   output logic        vid_active,
   output logic        vid_fend,
   output logic        hd_mode,
   output logic        pass
);

   logic run, ce, h_odd, active, upper, line_last, field_last, bar_first, vid_lend;
   logic [2:0] bar_idx;
   cfg_t cfg;
   logic unused_code_bits;

   assign unused_code_bits = ^pat_code[4:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cfg <= '0;
      end else begin
         run <= tpg_en;
         if (tpg_en && !run) begin
            cfg <= '{hd: pat_code[5], pat: pat_e'(pat_code[1:0]), filt: filt_en};
         end
      end
   end

   assign hd_mode = cfg.hd;

   vtpg_rate #(.SD_DIV(SD_DIV)) rate_i (
      .clk(clk), .rst_n(rst_n), .run(run), .hd(cfg.hd), .ce(ce)
   );

   vtpg_raster #(
      .SD_H_TOTAL(SD_H_TOTAL), .SD_H_ACT(SD_H_ACT),
      .SD_V_TOTAL(SD_V_TOTAL), .SD_V_ACT(SD_V_ACT),
      .HD_H_TOTAL(HD_H_TOTAL), .HD_H_ACT(HD_H_ACT),
      .HD_V_TOTAL(HD_V_TOTAL), .HD_V_ACT(HD_V_ACT),
      .N_BARS(8)
   ) raster_i (
      .clk(clk), .rst_n(rst_n), .run(run), .ce(ce), .hd(cfg.hd),
      .h_odd(h_odd), .active(active), .upper(upper),
      .line_last(line_last), .field_last(field_last),
      .bar_idx(bar_idx), .bar_first(bar_first)
   );

   vtpg_pattern #(.FILTER_EN(FILTER_EN)) pattern_i (
      .clk(clk), .rst_n(rst_n), .run(run), .ce(ce), .cfg(cfg),
      .h_odd(h_odd), .active(active), .upper(upper),
      .line_last(line_last), .field_last(field_last),
      .bar_idx(bar_idx), .bar_first(bar_first),
      .vid_data(vid_data), .pix_ce(pix_ce), .vid_active(vid_active),
      .vid_lend(vid_lend), .vid_fend(vid_fend)
   );

   vtpg_check #(.CSUM_W(CSUM_W), .PASS_FIELDS(PASS_FIELDS)) check_i (
      .clk(clk), .rst_n(rst_n), .run(run), .pix_ce(pix_ce),
      .vid_active(vid_active), .vid_lend(vid_lend), .vid_fend(vid_fend),
      .vid_data(vid_data), .lb_data(lb_data), .pass(pass)
   );

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(cfg));

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pix_ce);

endmodule

// File: tb/vtpg_top_tb.sv
`timescale 1ns/1ps
module vtpg_top_tb_top;

   localparam int SHT = 24, SHA = 16, SVT = 6, SVA = 4;
   localparam int HHT = 40, HHA = 32, HVT = 8, HVA = 6;
   localparam int SDIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tpg_en = 1'b0;
   logic [5:0]  pat_code = '0;
   logic        filt_en = 1'b0;
   logic [19:0] lb_mask = '0;
   logic [19:0] lb_data, vid_data;
   logic        pix_ce, vid_active, vid_fend, hd_mode, pass;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign lb_data = vid_data ^ lb_mask;

   vtpg_top #(
      .SD_H_TOTAL(SHT), .SD_H_ACT(SHA), .SD_V_TOTAL(SVT), .SD_V_ACT(SVA),
      .HD_H_TOTAL(HHT), .HD_H_ACT(HHA), .HD_V_TOTAL(HVT), .HD_V_ACT(HVA),
      .SD_DIV(SDIV)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tpg_en(tpg_en), .pat_code(pat_code),
      .filt_en(filt_en), .lb_data(lb_data), .vid_data(vid_data),
      .pix_ce(pix_ce), .vid_active(vid_active), .vid_fend(vid_fend),
      .hd_mode(hd_mode), .pass(pass)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [29:0] bar_tab(input int b);
      case (b)
         0: return {10'h2D0, 10'h200, 10'h200};
         1: return {10'h288, 10'h0B0, 10'h238};
         2: return {10'h20C, 10'h270, 10'h0B0};
         3: return {10'h1C0, 10'h120, 10'h0E8};
         4: return {10'h150, 10'h2E0, 10'h318};
         5: return {10'h104, 10'h190, 10'h350};
         6: return {10'h08C, 10'h350, 10'h1C8};
         default: return {10'h040, 10'h200, 10'h200};
      endcase
   endfunction

   function automatic logic [19:0] expw(input bit hd, input logic [1:0] pt,
                                        input bit filt, input int h, input int v);
      int ha = hd ? HHA : SHA;
      int va = hd ? HVA : SVA;
      int y = 'h040, cb = 'h200, cr = 'h200;
      if (h < ha && v < va) begin
         case (pt)
            2'd1: if (v >= va / 2) begin y = 'h110; cb = 'h200; cr = 'h200; end
            2'd2: if (v <  va / 2) begin y = 'h198; cb = 'h300; cr = 'h300; end
            2'd3: begin
               int bw = ha / 8;
               int b  = h / bw;
               logic [29:0] c = bar_tab(b);
               y = c[29:20]; cb = c[19:10]; cr = c[9:0];
               if (filt && b > 0 && h % bw == 0) begin
                  logic [29:0] p = bar_tab(b - 1);
                  y  = (y  + p[29:20]) / 2;
                  cb = (cb + p[19:10]) / 2;
                  cr = (cr + p[9:0])   / 2;
               end
            end
            default: ;
         endcase
      end
      return {y[9:0], (h % 2 == 1) ? cr[9:0] : cb[9:0]};
   endfunction

   task automatic reset_idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(pix_ce == 1'b0,   "R1", "pix_ce idle", pix_ce, 0);
      chk(vid_data == '0,   "R1", "vid_data idle", vid_data, 0);
      chk(vid_active == 1'b0 && vid_fend == 1'b0, "R1", "active/fend idle",
          {vid_active, vid_fend}, 0);
      chk(pass == 1'b0,     "R1", "pass idle", pass, 0);
      chk(hd_mode == 1'b0,  "R1", "hd_mode default SD", hd_mode, 0);
   endtask

   task automatic stop_chk();
      @(negedge clk);
      tpg_en = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(pix_ce == 1'b0 && vid_data == '0 && pass == 1'b0, "R12",
          "stopped outputs", {pix_ce, pass, vid_data}, 0);
      repeat (3) @(negedge clk);
   endtask

   // One scenario: start, walk nf fields comparing every sample, check pass
   task automatic run_scn(input string req, input logic [5:0] code, input bit filt,
                          input logic [5:0] code2, input bit filt2, input int nf,
                          input bit inj, input int ih, input int iv,
                          input bit exp_pass);
      bit hd = code[5];
      logic [1:0] pt = code[1:0];
      int ht = hd ? HHT : SHT;
      int vt = hd ? HVT : SVT;
      int ha = hd ? HHA : SHA;
      int va = hd ? HVA : SVA;
      int h = 0, v = 0, fc = 0, t = 0, last = -1, guard = 0;
      int bad = 0, badm = 0, badg = 0;
      logic [19:0] fa = '0, fe = '0;
      bit pass_due = 1'b0;
      @(negedge clk);
      pat_code = code;
      filt_en  = filt;
      tpg_en   = 1'b1;
      @(negedge clk);
      pat_code = code2;
      filt_en  = filt2;
      chk(hd_mode == hd, "R3", "hd_mode follows code bit 5", hd_mode, hd);
      while (fc < nf && guard < 50000) begin
         lb_mask = '0;
         if (pass_due) begin
            chk(pass == exp_pass, "R10 R11", "pass one clock after 2nd field end",
                pass, exp_pass);
            pass_due = 1'b0;
         end
         if (pix_ce) begin
            logic [19:0] e = expw(hd, pt, filt, h, v);
            bit ea = (h < ha) && (v < va);
            bit ef = (h == ht - 1) && (v == vt - 1);
            if (vid_data != e) begin
               if (bad == 0) begin fa = vid_data; fe = e; end
               bad++;
            end
            if (vid_active != ea || vid_fend != ef) badm++;
            if (last >= 0 && (t - last) != (hd ? 1 : SDIV)) badg++;
            last = t;
            if (inj && fc == 0 && h == ih && v == iv) lb_mask = 20'h00400;
            if (ef) begin
               fc++;
               if (fc == 2) begin
                  chk(pass == 1'b0, "R10", "pass low before 2nd field completes", pass, 0);
                  pass_due = 1'b1;
               end
            end
            if (h == ht - 1) begin
               h = 0;
               v = (v == vt - 1) ? 0 : v + 1;
            end else begin
               h++;
            end
         end
         @(negedge clk);
         t++;
         guard++;
      end
      lb_mask = '0;
      if (pass_due) begin
         chk(pass == exp_pass, "R10 R11", "pass one clock after 2nd field end",
             pass, exp_pass);
      end
      chk(pass == exp_pass, "R10 R11", "pass at end of run", pass, exp_pass);
      chk(bad == 0, req, "sample words", fa, fe);
      chk(badm == 0, "R4", "active/field-end flags wrong count", badm, 0);
      chk(badg == 0, "R3", "pix_ce spacing errors", badg, 0);
      stop_chk();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      reset_idle();
      // R8 R5: SD bars, no filter
      run_scn("R8 R5", 6'h03, 1'b0, 6'h03, 1'b0, 2, 1'b0, 0, 0, 1'b1);
      // R9: HD bars with transition filter
      run_scn("R9 R8", 6'h23, 1'b1, 6'h23, 1'b1, 2, 1'b0, 0, 0, 1'b1);
      // R7: SD equalizer-stress half field
      run_scn("R7", 6'h02, 1'b0, 6'h02, 1'b0, 2, 1'b0, 0, 0, 1'b1);
      // R7 R2: SD PLL-stress with ignored bits [4:2] set
      run_scn("R7 R2", 6'h1D, 1'b0, 6'h1D, 1'b0, 2, 1'b0, 0, 0, 1'b1);
      // R6 R2: HD black; code and filter change mid-run must not take effect
      run_scn("R6 R2", 6'h20, 1'b0, 6'h03, 1'b1, 2, 1'b0, 0, 0, 1'b1);
      // R11: HD PLL-stress, error on an active sample -> no pass over 3 fields
      run_scn("R7 R11", 6'h21, 1'b0, 6'h21, 1'b0, 3, 1'b1, 3, 1, 1'b0);
      // R11 R12: error only in blanking is ignored; restart clears failure
      run_scn("R8 R11 R12", 6'h03, 1'b0, 6'h03, 1'b0, 2, 1'b1, SHA + 2, 1, 1'b1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule